// File: doc/BRIEF.md
# E3 Maintenance Byte Monitor

This block watches the once-per-frame maintenance-and-adaptation byte of a byte-structured E3 frame. Upstream logic finds that byte and presents it with a one-cycle strobe. An in-frame qualifier says whether frame alignment is currently held.

The block filters two single-bit indications through consecutive-frame persistence: the far-end receive failure (FERF) bit and the timing marker bit. A select input sets the run length to 3 or 5 frames. The three payload type bits are latched once the same value has been seen in two frames in a row.

Each validated value has its own one-cycle change pulse, and each frame's far-end block error bit comes out as a one-cycle pulse for an external counter. Every output is registered and changes on the clock edge that samples the strobe.

Byte layout, most significant bit first: bit 7 FERF, bit 6 far-end block error, bits 5:3 payload type, bits 2:1 multiframe indicator (not used here), bit 0 timing marker.

Top module: `e3_ma_monitor`

## Requirements
- R1: Out of reset, `ferf_state`, `tmark_state`, `ptype` and all pulse outputs are 0. `ferf_state` becomes 1 after bit 7 is 1 in N consecutive qualified strobes. N is 3 when `persist_five` is 0 and 5 when it is 1.
- R2: `ferf_state` returns to 0 after bit 7 is 0 in N consecutive qualified strobes.
- R3: `ferf_chg` pulses high for exactly one cycle in the cycle `ferf_state` changes, and at no other time.
- R4: `tmark_state` follows bit 0 under the same N-frame rule as R1/R2. `tmark_chg` pulses for one cycle on each change.
- R5: A qualified strobe whose bit equals the current validated value restarts that bit's run. A run broken before N frames therefore changes nothing.
- R6: `ptype` (bits 5:3) takes a new value only when that value arrives in two consecutive qualified strobes and differs from the held one. `ptype_chg` pulses for one cycle on each update.
- R7: While `in_frame` is 0, strobes are ignored, and all runs and the payload type candidate restart.
- R8: `febe_pulse` is high for one cycle after a qualified strobe whose bit 6 is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ma_byte | input | 8 | Maintenance byte of the current frame |
| ma_valid | input | 1 | One-cycle strobe marking `ma_byte` valid |
| in_frame | input | 1 | Frame alignment held |
| persist_five | input | 1 | 0: 3-frame runs, 1: 5-frame runs |
| ferf_state | output | 1 | Validated far-end receive failure |
| tmark_state | output | 1 | Validated timing marker |
| ptype | output | 3 | Latched payload type |
| ferf_chg | output | 1 | Pulse on FERF change |
| tmark_chg | output | 1 | Pulse on timing marker change |
| ptype_chg | output | 1 | Pulse on payload type update |
| febe_pulse | output | 1 | Per-frame far-end block error pulse |

## Verification
The bench drives runs one frame shorter than N and checks that nothing toggles. A filter that is off by one would switch early there.

It breaks a run with one agreeing frame to catch a counter that never clears. It also drops `in_frame` partway through a run: a design that kept the partial count, or counted ignored strobes, would declare too soon.

For payload type, it alternates values so that no value ever repeats. A latch that took a single frame would follow that alternation. Change pulses are checked on steady frames as well, which exposes a pulse that fires on every strobe.

// File: rtl/e3_ma_monitor.sv
module e3_ma_monitor #(
  parameter int SHORT_RUN = 3,
  parameter int LONG_RUN  = 5,
  parameter int FERF_POS  = 7,
  parameter int FEBE_POS  = 6,
  parameter int PT_LSB    = 3,
  parameter int PT_W      = 3,
  parameter int TM_POS    = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      ma_byte,
  input  logic            ma_valid,
  input  logic            in_frame,
  input  logic            persist_five,
  output logic            ferf_state,
  output logic            tmark_state,
  output logic [PT_W-1:0] ptype,
  output logic            ferf_chg,
  output logic            tmark_chg,
  output logic            ptype_chg,
  output logic            febe_pulse
);

  localparam int CW = $clog2(LONG_RUN + 1);
  localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_RUN - 1);
  localparam logic [CW-1:0] LONG_M1  = CW'(LONG_RUN - 1);

  wire            take   = ma_valid & in_frame;
  wire [CW-1:0]   last_k = persist_five ? LONG_M1 : SHORT_M1;
  wire [PT_W-1:0] pt_in  = ma_byte[PT_LSB +: PT_W];

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_flt
      localparam int BP = (g == 0) ? FERF_POS : TM_POS;
      logic [CW-1:0] run_q;
      logic          st_q;
      logic          chg_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          run_q <= '0;
          st_q  <= 1'b0;
          chg_q <= 1'b0;
        end else begin
          chg_q <= 1'b0;
          if (!in_frame) begin
            run_q <= '0;
          end else if (ma_valid) begin
            if (ma_byte[BP] == st_q) begin
              run_q <= '0;
            end else if (run_q >= last_k) begin
              st_q  <= ~st_q;
              chg_q <= 1'b1;
              run_q <= '0;
            end else begin
              run_q <= run_q + 1'b1;
            end
          end
        end
      end

      p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= LONG_M1);
    end
  endgenerate

  assign ferf_state  = g_flt[0].st_q;
  assign ferf_chg    = g_flt[0].chg_q;
  assign tmark_state = g_flt[1].st_q;
  assign tmark_chg   = g_flt[1].chg_q;

  logic [PT_W-1:0] cand_q;
  logic            cand_ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptype      <= '0;
      cand_q     <= '0;
      cand_ok_q  <= 1'b0;
      ptype_chg  <= 1'b0;
      febe_pulse <= 1'b0;
    end else begin
      ptype_chg  <= 1'b0;
      febe_pulse <= take & ma_byte[FEBE_POS];
      if (!in_frame) begin
        cand_ok_q <= 1'b0;
      end else if (ma_valid) begin
        cand_q    <= pt_in;
        cand_ok_q <= 1'b1;
        if (cand_ok_q && cand_q == pt_in && pt_in != ptype) begin
          ptype     <= pt_in;
          ptype_chg <= 1'b1;
        end
      end
    end
  end

  p_ferf_chg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ferf_state != $past(ferf_state)) == ferf_chg);
  p_ferf_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ferf_state) |-> $past(take));
  p_tmark_chg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tmark_state != $past(tmark_state)) == tmark_chg);
  p_ptype_chg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ptype) |-> ptype_chg);
  p_ptype_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ptype_chg |-> $past(take) && ptype == $past(pt_in));
  p_febe_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    febe_pulse |-> $past(take && ma_byte[FEBE_POS]));
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_frame) |-> !ferf_chg && !tmark_chg && !ptype_chg && !febe_pulse);

endmodule

// File: tb/e3_ma_monitor_tb_top.sv
`timescale 1ns/1ps
module e3_ma_monitor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ma_byte = 8'h00;
  logic       ma_valid = 1'b0;
  logic       in_frame = 1'b1;
  logic       persist_five = 1'b0;
  logic       ferf_state, tmark_state, ferf_chg, tmark_chg, ptype_chg, febe_pulse;
  logic [2:0] ptype;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  e3_ma_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .ma_byte(ma_byte), .ma_valid(ma_valid),
    .in_frame(in_frame), .persist_five(persist_five),
    .ferf_state(ferf_state), .tmark_state(tmark_state), .ptype(ptype),
    .ferf_chg(ferf_chg), .tmark_chg(tmark_chg), .ptype_chg(ptype_chg),
    .febe_pulse(febe_pulse)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    ma_byte  = b;
    ma_valid = 1'b1;
    @(negedge clk);
    ma_valid = 1'b0;
    repeat (2) @(negedge clk);
    ma_byte  = b;
  endtask

  task automatic send_now(input logic [7:0] b);
    @(negedge clk);
    ma_byte  = b;
    ma_valid = 1'b1;
    @(negedge clk);
    ma_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(ferf_state, 0, "R1 reset ferf");
    chk(tmark_state, 0, "R1 reset tmark");
    chk(ptype, 0, "R1 reset ptype");
    chk(ferf_chg | tmark_chg | ptype_chg | febe_pulse, 0, "R1 reset pulses");
  endtask

  task automatic t_ferf_set();
    send(8'h80); send(8'h80);
    chk(ferf_state, 0, "R1 ferf held after 2 of 3");
    send_now(8'h80);
    chk(ferf_state, 1, "R1 ferf set after 3");
    chk(ferf_chg, 1, "R3 ferf_chg on set");
    @(negedge clk);
    chk(ferf_chg, 0, "R3 ferf_chg one cycle");
    send_now(8'h80);
    chk(ferf_chg, 0, "R3 no pulse on steady frame");
  endtask

  task automatic t_ferf_clear();
    send(8'h00); send(8'h00); send(8'h80);
    send(8'h00); send(8'h00);
    chk(ferf_state, 1, "R5 broken run does not clear");
    send_now(8'h00);
    chk(ferf_state, 0, "R2 ferf cleared after 3");
    chk(ferf_chg, 1, "R3 ferf_chg on clear");
  endtask

  task automatic t_tmark_five();
    persist_five = 1'b1;
    for (int i = 0; i < 4; i++) send(8'h01);
    chk(tmark_state, 0, "R4 tmark held after 4 of 5");
    send_now(8'h01);
    chk(tmark_state, 1, "R4 tmark set after 5");
    chk(tmark_chg, 1, "R4 tmark_chg");
    persist_five = 1'b0;
  endtask

  task automatic t_in_frame();
    send(8'h81); send(8'h81);
    in_frame = 1'b0;
    send(8'h81);
    chk(ferf_state, 0, "R7 strobe ignored out of frame");
    in_frame = 1'b1;
    send(8'h81); send(8'h81);
    chk(ferf_state, 0, "R7 run restarted after in_frame low");
    send(8'h81);
    chk(ferf_state, 1, "R7 ferf set after full fresh run");
  endtask

  task automatic t_ptype();
    send_now(8'hA9);
    chk(ptype, 0, "R6 single frame not taken");
    chk(ptype_chg, 0, "R6 no pulse on first frame");
    send_now(8'hA9);
    chk(ptype, 5, "R6 ptype after pair");
    chk(ptype_chg, 1, "R6 ptype_chg");
    send(8'h91); send(8'hA9); send(8'h91); send(8'hA9);
    chk(ptype, 5, "R6 alternating values ignored");
    send(8'h91);
    send_now(8'h91);
    chk(ptype, 2, "R6 ptype second update");
    chk(ptype_chg, 1, "R6 ptype_chg second");
  endtask

  task automatic t_febe();
    send_now(8'hD1);
    chk(febe_pulse, 1, "R8 febe pulse");
    @(negedge clk);
    chk(febe_pulse, 0, "R8 febe one cycle");
    in_frame = 1'b0;
    send_now(8'hD1);
    chk(febe_pulse, 0, "R8 febe suppressed out of frame");
    in_frame = 1'b1;
    send_now(8'h91);
    chk(febe_pulse, 0, "R8 no febe when bit 6 is 0");
    chk(ferf_state, 1, "R5 ferf steady");
    chk(tmark_state, 1, "R4 tmark steady");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ferf_set();
    t_ferf_clear();
    t_tmark_five();
    t_in_frame();
    t_ptype();
    t_febe();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule